// File: doc/BRIEF.md
# Video Timing Reference Decoder

This block sits on the receive side of a parallel 4:2:2 digital video port and finds the embedded timing reference codes in the word stream. A timing code is a three-word preamble (all ones, all zeros, all zeros) followed by a status word. The status word reports the start or end of the active part of a line, the field, vertical blanking and a task bit. The task bit lets two independent video streams share one port, alternating per line or per field. The low nibble of the status word carries a progressive-source marker, a repeat-field marker for 3:2 pull-down, a reserved bit and an extension bit. The extension bit announces one extra flag word directly after an end-of-active code.

A static mode input selects the port width. In narrow mode each clock carries one byte on the low lane. In wide mode the upper lane carries luma and the lower lane carries chroma, and codes are searched on the upper lane only. Each clock the block emits single-cycle start and end events and holds the decoded flags. It also presents the input word on a pixel output, with a valid strobe that is high only for active video words. All outputs are registered and appear one clock after the word that causes them.

Top module: `vid_timing_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it is released with no code yet seen, every output is zero.
- R2: In narrow mode (wide16 = 0) the code lane is din[7:0], and din[15:8] plays no part in code detection. The words FF, 00, 00, XY on consecutive clocks raise exactly one of sav_pulse or eav_pulse for one cycle, in the clock after XY is sampled. XY bit 4 = 1 selects eav_pulse and XY bit 4 = 0 selects sav_pulse.
- R3: In wide mode (wide16 = 1) the code lane is din[15:8], and a preamble pattern on din[7:0] raises no event.
- R4: Every detected code, start or end, loads task_id from XY bit 7, field from bit 6 and vblank from bit 5. These outputs hold their values until the next code.
- R5: Every detected code loads non_int from XY bit 3 and repeat_fld from bit 2. XY bit 1 is reserved and changes no output.
- R6: An end-of-active code with XY bit 0 = 1 makes the next code-lane value load into ext_flags. That word can never be the first word of a preamble. Bit 0 of a start-of-active code is ignored.
- R7: After a start-of-active code with XY bit 5 = 0, each following word raises active_valid one clock later, with pix_data equal to that word. This stops at the next end-of-active code. Words whose code lane is FF or 00 never raise active_valid, and neither do the code status words themselves.
- R8: A start-of-active code with XY bit 5 = 1 (vertical blanking) starts no active words.
- R9: Blanking filler (80, 10) and broken preambles such as FF, 00, XY or FF, 00, 01, XY raise no event and no active_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide16 | input | 1 | Static port width select: 0 narrow, 1 wide |
| din | input | 16 | Incoming video word |
| pix_data | output | 16 | Input word delayed one clock |
| active_valid | output | 1 | pix_data holds an active video word |
| task_id | output | 1 | Stream tag from the last code |
| field | output | 1 | Field flag from the last code |
| vblank | output | 1 | Vertical blanking flag from the last code |
| sav_pulse | output | 1 | Start-of-active code seen |
| eav_pulse | output | 1 | End-of-active code seen |
| non_int | output | 1 | Progressive source marker from the last code |
| repeat_fld | output | 1 | Repeat-field marker from the last code |
| ext_flags | output | 8 | Last extra flag word |

## Verification
The bench sends an extra flag word of FF followed by 00, 00 and a valid status word. A decoder that let the flag word into the preamble history would report a false end-of-active event there. It checks that the three preamble words ending an active line are not marked as pixels; a design that cleared the active state only on the status word would pass them through. Wide mode is tested with a full preamble placed on the chroma lane, which a decoder watching the wrong lane would accept. Start codes carrying the reserved bit or the extension bit are also sent, to catch decoders that load flags from the wrong bit or that capture a flag word after a start code.

// File: rtl/vtd_pkg.sv
package vtd_pkg;
  // Offsets of status-word fields, counted down from the lane MSB.
  localparam int unsigned OFS_TASK   = 0;
  localparam int unsigned OFS_FIELD  = 1;
  localparam int unsigned OFS_VBLANK = 2;
  localparam int unsigned OFS_HFLAG  = 3;
  localparam int unsigned OFS_NONINT = 4;
  localparam int unsigned OFS_REPEAT = 5;
  localparam int unsigned OFS_EXT    = 7;
  localparam int unsigned PRE_LEN    = 3;
endpackage

// File: rtl/vtd_preamble.sv
module vtd_preamble #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] code_byte,
  input  logic              squash,
  output logic              match
);
  import vtd_pkg::*;
  localparam logic [LANE_W-1:0] ONES = '1;
  localparam logic [LANE_W-1:0] ZERO = '0;

  logic [LANE_W-1:0] hist [PRE_LEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PRE_LEN; i++) hist[i] <= ZERO;
    end else begin
      hist[0] <= squash ? ZERO : code_byte;
      for (int i = 1; i < PRE_LEN; i++) hist[i] <= hist[i-1];
    end
  end

  assign match = !squash && (hist[2] == ONES) && (hist[1] == ZERO) && (hist[0] == ZERO);
endmodule

// File: rtl/vtd_flags.sv
module vtd_flags #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              match,
  input  logic [LANE_W-1:0] code_byte,
  output logic              task_id,
  output logic              field,
  output logic              vblank,
  output logic              sav_pulse,
  output logic              eav_pulse,
  output logic              non_int,
  output logic              repeat_fld,
  output logic [LANE_W-1:0] ext_flags,
  output logic              ext_pend
);
  import vtd_pkg::*;
  localparam int unsigned TOP = LANE_W - 1;

  logic is_end;
  assign is_end = code_byte[TOP-OFS_HFLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      task_id    <= 1'b0;
      field      <= 1'b0;
      vblank     <= 1'b0;
      sav_pulse  <= 1'b0;
      eav_pulse  <= 1'b0;
      non_int    <= 1'b0;
      repeat_fld <= 1'b0;
      ext_flags  <= '0;
      ext_pend   <= 1'b0;
    end else begin
      sav_pulse <= match && !is_end;
      eav_pulse <= match && is_end;
      ext_pend  <= match && is_end && code_byte[TOP-OFS_EXT];
      if (match) begin
        task_id    <= code_byte[TOP-OFS_TASK];
        field      <= code_byte[TOP-OFS_FIELD];
        vblank     <= code_byte[TOP-OFS_VBLANK];
        non_int    <= code_byte[TOP-OFS_NONINT];
        repeat_fld <= code_byte[TOP-OFS_REPEAT];
      end
      if (ext_pend) ext_flags <= code_byte;
    end
  end
endmodule

// File: rtl/vtd_active.sv
module vtd_active #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              match,
  input  logic [LANE_W-1:0] code_byte,
  input  logic [WORD_W-1:0] din,
  output logic              active_valid,
  output logic [WORD_W-1:0] pix_data
);
  import vtd_pkg::*;
  localparam int unsigned TOP = LANE_W - 1;
  localparam logic [LANE_W-1:0] ONES = '1;
  localparam logic [LANE_W-1:0] ZERO = '0;

  logic in_active;
  logic reserved_val;
  assign reserved_val = (code_byte == ONES) || (code_byte == ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_active    <= 1'b0;
      active_valid <= 1'b0;
      pix_data     <= '0;
    end else begin
      if (match)
        in_active <= !code_byte[TOP-OFS_HFLAG] && !code_byte[TOP-OFS_VBLANK];
      active_valid <= in_active && !match && !reserved_val;
      pix_data     <= din;
    end
  end
endmodule

// File: rtl/vid_timing_decoder.sv
module vid_timing_decoder #(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned WORD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide16,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] pix_data,
  output logic              active_valid,
  output logic              task_id,
  output logic              field,
  output logic              vblank,
  output logic              sav_pulse,
  output logic              eav_pulse,
  output logic              non_int,
  output logic              repeat_fld,
  output logic [LANE_W-1:0] ext_flags
);
  logic [LANE_W-1:0] code_byte;
  logic              match;
  logic              ext_pend;

  assign code_byte = wide16 ? din[WORD_W-1:LANE_W] : din[LANE_W-1:0];

  vtd_preamble #(.LANE_W(LANE_W)) u_pre (
    .clk(clk), .rst(rst), .code_byte(code_byte), .squash(ext_pend), .match(match)
  );

  vtd_flags #(.LANE_W(LANE_W)) u_flg (
    .clk(clk), .rst(rst), .match(match), .code_byte(code_byte),
    .task_id(task_id), .field(field), .vblank(vblank),
    .sav_pulse(sav_pulse), .eav_pulse(eav_pulse),
    .non_int(non_int), .repeat_fld(repeat_fld),
    .ext_flags(ext_flags), .ext_pend(ext_pend)
  );

  vtd_active #(.LANE_W(LANE_W), .WORD_W(WORD_W)) u_act (
    .clk(clk), .rst(rst), .match(match), .code_byte(code_byte), .din(din),
    .active_valid(active_valid), .pix_data(pix_data)
  );
endmodule

// File: rtl/vtd_checker.sv
module vtd_checker (
  input logic clk,
  input logic rst,
  input logic active_valid,
  input logic task_id,
  input logic field,
  input logic vblank,
  input logic sav_pulse,
  input logic eav_pulse
);
  // R2: a code is either start or end, never both
  p_one_kind_r2: assert property (@(posedge clk) disable iff (rst)
    !(sav_pulse && eav_pulse));

  // R4: flags move only in the cycle a code is reported
  p_flags_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!sav_pulse && !eav_pulse) |-> $stable({task_id, field, vblank}));

  // R7: the end code word is not a pixel, nor the word after it
  p_end_not_pix_r7: assert property (@(posedge clk) disable iff (rst)
    eav_pulse |-> !active_valid);
  p_after_end_r7: assert property (@(posedge clk) disable iff (rst)
    eav_pulse |=> !active_valid);

  // R8: no pixels while the last code marked vertical blanking
  p_no_pix_vblank_r8: assert property (@(posedge clk) disable iff (rst)
    active_valid |-> !vblank);

  // R9: a full preamble needs four words, so events never come back to back
  p_event_gap_r9: assert property (@(posedge clk) disable iff (rst)
    (sav_pulse || eav_pulse) |=> !(sav_pulse || eav_pulse));
endmodule

bind vid_timing_decoder vtd_checker u_chk (
  .clk(clk), .rst(rst), .active_valid(active_valid), .task_id(task_id),
  .field(field), .vblank(vblank), .sav_pulse(sav_pulse), .eav_pulse(eav_pulse)
);

// File: tb/sim_vid_timing_decoder.sv
`timescale 1ns/1ps
module sim_vid_timing_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide16 = 1'b0;
  logic [15:0] din = 16'h0010;
  logic [15:0] pix_data;
  logic        active_valid, task_id, field, vblank, sav_pulse, eav_pulse;
  logic        non_int, repeat_fld;
  logic [7:0]  ext_flags;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vid_timing_decoder u0 (
    .clk(clk), .rst(rst), .wide16(wide16), .din(din), .pix_data(pix_data),
    .active_valid(active_valid), .task_id(task_id), .field(field), .vblank(vblank),
    .sav_pulse(sav_pulse), .eav_pulse(eav_pulse), .non_int(non_int),
    .repeat_fld(repeat_fld), .ext_flags(ext_flags)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one word, then sample just after the edge that registers it
  task automatic put(input logic [15:0] w);
    @(negedge clk);
    din = w;
    @(posedge clk);
    #1;
  endtask

  task automatic put8(input logic [7:0] b);
    put({8'hA5, b});
  endtask

  task automatic code8(input logic [7:0] xy);
    put8(8'hFF); put8(8'h00); put8(8'h00); put8(xy);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; wide16 = mode; din = 16'h1080;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 flags", {9'd0, active_valid, task_id, field, vblank, sav_pulse, eav_pulse, non_int, repeat_fld}, 16'h0);
    chk("R1 ext_flags", {8'h00, ext_flags}, 16'h0);
  endtask

  task automatic t_end_narrow;
    put8(8'h80); put8(8'h10);
    chk("R9 filler", {14'd0, sav_pulse, eav_pulse}, 16'h0);
    code8(8'hB0); // T1 F0 V1 H1
    chk("R2 eav", {14'd0, sav_pulse, eav_pulse}, 16'h1);
    chk("R4 flags eav", {13'd0, task_id, field, vblank}, 16'h5);
    put8(8'h80);
    chk("R2 single pulse", {14'd0, sav_pulse, eav_pulse}, 16'h0);
    chk("R4 hold", {13'd0, task_id, field, vblank}, 16'h5);
  endtask

  task automatic t_active_line;
    code8(8'h4E); // T0 F1 V0 H0, non_int, repeat, reserved
    chk("R2 sav", {14'd0, sav_pulse, eav_pulse}, 16'h2);
    chk("R4 flags sav", {13'd0, task_id, field, vblank}, 16'h2);
    chk("R5 nibble", {14'd0, non_int, repeat_fld}, 16'h3);
    chk("R7 code word not pixel", {15'd0, active_valid}, 16'h0);
    for (int i = 0; i < 4; i++) begin
      put8(8'h20 + 8'(i * 16));
      chk("R7 pixel valid", {15'd0, active_valid}, 16'h1);
      chk("R7 pixel data", pix_data, {8'hA5, 8'h20 + 8'(i * 16)});
    end
    put8(8'hFF); chk("R7 preamble FF", {15'd0, active_valid}, 16'h0);
    put8(8'h00); chk("R7 preamble 00", {15'd0, active_valid}, 16'h0);
    put8(8'h00); chk("R7 preamble 00b", {15'd0, active_valid}, 16'h0);
    put8(8'h50);
    chk("R7 eav ends", {14'd0, active_valid, eav_pulse}, 16'h1);
    chk("R5 nibble cleared", {14'd0, non_int, repeat_fld}, 16'h0);
    put8(8'h44);
    chk("R7 after eav", {15'd0, active_valid}, 16'h0);
  endtask

  task automatic t_reserved;
    code8(8'h42); // reserved bit only
    chk("R5 reserved", {14'd0, non_int, repeat_fld}, 16'h0);
    put8(8'h66);
    chk("R5 reserved no capture", {7'd0, active_valid, ext_flags}, 16'h0100);
    code8(8'h41); // start code with ext bit
    put8(8'h33);
    chk("R6 sav ext ignored", {7'd0, active_valid, ext_flags}, 16'h0100);
    code8(8'h50);
  endtask

  task automatic t_vblank_line;
    code8(8'h20); // V1 H0
    chk("R8 sav vblank", {14'd0, sav_pulse, vblank}, 16'h3);
    put8(8'h55);
    chk("R8 no pixels", {15'd0, active_valid}, 16'h0);
    put8(8'h66);
    chk("R8 no pixels b", {15'd0, active_valid}, 16'h0);
  endtask

  task automatic t_ext_flag;
    code8(8'h11); // H1 ext
    chk("R6 eav", {14'd0, sav_pulse, eav_pulse}, 16'h1);
    put8(8'hFF);
    chk("R6 captured", {8'h00, ext_flags}, 16'h00FF);
    put8(8'h00); put8(8'h00); put8(8'h90);
    chk("R6 flag word not preamble", {14'd0, sav_pulse, eav_pulse}, 16'h0);
    chk("R6 task held", {15'd0, task_id}, 16'h0);
    code8(8'h90);
    chk("R6 later code", {14'd0, task_id, eav_pulse}, 16'h3);
  endtask

  task automatic t_broken;
    put8(8'hFF); put8(8'h00); put8(8'h80);
    chk("R9 short preamble", {14'd0, sav_pulse, eav_pulse}, 16'h0);
    put8(8'hFF); put8(8'h00); put8(8'h01); put8(8'h80);
    chk("R9 corrupt preamble", {14'd0, sav_pulse, eav_pulse}, 16'h0);
    chk("R9 flags held", {15'd0, task_id}, 16'h1);
  endtask

  task automatic t_wide;
    do_reset(1'b1);
    put(16'h80FF); put(16'h1000); put(16'h8000); put(16'h1090);
    chk("R3 low lane ignored", {14'd0, sav_pulse, eav_pulse}, 16'h0);
    put(16'hFF80); put(16'h0010); put(16'h0080); put(16'h8010);
    chk("R3 wide sav", {13'd0, sav_pulse, task_id, vblank}, 16'h6);
    put(16'h6070);
    chk("R3 wide pixel", {15'd0, active_valid}, 16'h1);
    chk("R3 wide data", pix_data, 16'h6070);
    put(16'hFF00); put(16'h0000); put(16'h0000); put(16'h1000);
    chk("R3 wide eav", {13'd0, eav_pulse, task_id, active_valid}, 16'h4);
  endtask

  initial begin
    do_reset(1'b0);
    t_reset();
    t_end_narrow();
    t_active_line();
    t_reserved();
    t_vblank_line();
    t_ext_flag();
    t_broken();
    t_wide();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule